// File: doc/BRIEF.md
# Dual-Source Interrupt Request Arbiter

This block is the interrupt front end of a peripheral that has two interrupt sources: a queued SPI engine and a UART-style serial interface. Software gives each source its own three-bit priority level. The block raises one of seven internal request lines, picked from the levels of the sources whose flags are set. The higher level wins. When both levels are equal, the SPI engine wins.

An interrupt-acknowledge cycle begins with a one-cycle start pulse that carries the level the processor is serving. The block checks that level against its own highest pending request. On a match it enters bit-serial contention on an open-drain (wired-AND) line, sending a four-bit module arbitration number MSB first. If it survives all four bits, it presents an eight-bit vector for one cycle. The top seven bits of the vector are a shared base, and the low bit names the source. A module whose arbitration number is zero never answers, so the processor sees a spurious interrupt.

Top module: `dual_irq_front`

## Requirements
- R1: After reset both levels, the arbitration number and the vector base are zero, so no request line is asserted (even with flags set), `arb_release` is 1 and `vec_valid` is 0.
- R2: A source with a set flag and a nonzero level L asserts request line L only (bit L-1 of `irq_line`). A source with level 0 never requests. No request line is asserted when neither flag is set.
- R3: When both sources request at different levels, only the line of the higher level is asserted.
- R4: On an acknowledge start pulse, the block contends only when `iack_level` equals the level of its highest pending request. Otherwise `arb_release` stays 1 and no vector is given.
- R5: With an arbitration number of zero, the block never contends and never gives a vector.
- R6: While contending, in the k-th cycle after the start edge (k = 0..3), `arb_release` equals bit 3-k of the arbitration number. The block drops out, and drives 1 from then on, as soon as it drives 1 and samples 0 on `arb_bus_in` at a clock edge.
- R7: A block that survives all four bits asserts `vec_valid` for exactly one cycle, in the cycle after the fourth bit. `vec_valid` is 0 during contention.
- R8: Vector bits 7..1 are the base and bit 0 is the source: 1 for the SPI engine, 0 for the serial interface. When both levels are equal and both sources are pending, the SPI engine is served.
- R9: An acknowledge does not clear a request; the request line stays asserted while the source flag is set.
- R10: A write with `cfg_wr` high stores into one register, chosen by `cfg_addr`. Address 0 holds the SPI level (data bits 2..0). Address 1 holds the serial level (data bits 2..0). Address 2 holds the arbitration number (data bits 3..0). Address 3 holds the vector base (data bits 7..1; data bit 0 is ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_data | input | 8 | Configuration write data |
| spi_flag | input | 1 | SPI engine interrupt flag |
| ser_flag | input | 1 | Serial interface interrupt flag |
| irq_line | output | 7 | Request lines; bit i is line i+1 |
| iack_start | input | 1 | One-cycle start of an acknowledge cycle |
| iack_level | input | 3 | Level being acknowledged |
| arb_bus_in | input | 1 | Resolved value of the wired-AND contention line |
| arb_release | output | 1 | Bit driven onto the contention line (1 = released) |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_num | output | 8 | Interrupt vector number |

## Verification
Every combination of the two levels and the two flags is applied and compared with the one-hot line of the larger enabled level. This separates the disabled-at-zero case, the higher-wins case and the SPI tie case. Acknowledges are swept over every mask level against a competing module that is absent, or holds a smaller or larger number. This shows matching against mismatching masks, and the first bit at which either side drops out. Further runs change which source is pending, set the arbitration number to zero and write a base with its low bit set. These show the source bit, the spurious case and the ignored data bit.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
   typedef enum logic [1:0] {
      ACK_IDLE = 2'd0,
      ACK_ARB  = 2'd1,
      ACK_RESP = 2'd2
   } ack_state_t;

   localparam logic [1:0] CFG_SEL_SPI_LVL = 2'd0;
   localparam logic [1:0] CFG_SEL_SER_LVL = 2'd1;
   localparam logic [1:0] CFG_SEL_ARB_NUM = 2'd2;
   localparam logic [1:0] CFG_SEL_VEC_BASE = 2'd3;
endpackage

// File: rtl/dirq_cfg.sv
module dirq_cfg #(
   parameter int LVL_W = 3,
   parameter int ARB_W = 4,
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [VEC_W-1:0] wr_data,
   output logic [LVL_W-1:0] lvl_spi,
   output logic [LVL_W-1:0] lvl_ser,
   output logic [ARB_W-1:0] arb_num,
   output logic [VEC_W-2:0] vec_base
);
   import dirq_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_spi  <= '0;
         lvl_ser  <= '0;
         arb_num  <= '0;
         vec_base <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            CFG_SEL_SPI_LVL:  lvl_spi  <= wr_data[LVL_W-1:0];
            CFG_SEL_SER_LVL:  lvl_ser  <= wr_data[LVL_W-1:0];
            CFG_SEL_ARB_NUM:  arb_num  <= wr_data[ARB_W-1:0];
            default:          vec_base <= wr_data[VEC_W-1:1];
         endcase
      end
   end
endmodule

// File: rtl/dirq_level.sv
module dirq_level #(
   parameter int LVL_W        = 3,
   parameter bit SPI_WINS_TIE = 1'b1,
   localparam int NUM_LINES   = (1 << LVL_W) - 1
) (
   input  logic                 flag_spi,
   input  logic                 flag_ser,
   input  logic [LVL_W-1:0]     lvl_spi,
   input  logic [LVL_W-1:0]     lvl_ser,
   output logic [NUM_LINES-1:0] lines,
   output logic [LVL_W-1:0]     top_level,
   output logic                 top_is_spi
);
   logic [LVL_W-1:0] eff_spi;
   logic [LVL_W-1:0] eff_ser;
   logic             spi_sel;

   assign eff_spi = flag_spi ? lvl_spi : '0;
   assign eff_ser = flag_ser ? lvl_ser : '0;

   generate
      if (SPI_WINS_TIE) begin : g_tie_spi
         assign spi_sel = (eff_spi != '0) && (eff_spi >= eff_ser);
      end else begin : g_tie_ser
         assign spi_sel = (eff_spi > eff_ser);
      end
   endgenerate

   assign top_level  = spi_sel ? eff_spi : eff_ser;
   assign top_is_spi = spi_sel;

   generate
      for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
         assign lines[gi] = (top_level == LVL_W'(gi + 1));
      end
   endgenerate
endmodule

// File: rtl/dirq_contend.sv
module dirq_contend #(
   parameter int LVL_W = 3,
   parameter int ARB_W = 4,
   parameter int VEC_W = 8,
   localparam int CNT_W = (ARB_W > 1) ? $clog2(ARB_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LVL_W-1:0] ack_level,
   input  logic [LVL_W-1:0] top_level,
   input  logic             top_is_spi,
   input  logic [ARB_W-1:0] arb_num,
   input  logic [VEC_W-2:0] vec_base,
   input  logic             bus_in,
   output logic             release_o,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_num
);
   import dirq_pkg::*;

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ARB_W - 1);

   ack_state_t       state_q;
   logic [CNT_W-1:0] bit_q;
   logic [ARB_W-1:0] shift_q;
   logic             alive_q;
   logic             src_q;
   logic             cur_bit;
   logic             lose_now;
   logic             join_now;

   assign cur_bit  = shift_q[ARB_W-1];
   assign join_now = start && (arb_num != '0) && (top_level != '0)
                     && (ack_level == top_level);
   assign lose_now = (state_q == ACK_ARB) && alive_q && cur_bit && !bus_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ACK_IDLE;
         bit_q   <= '0;
         shift_q <= '0;
         alive_q <= 1'b0;
         src_q   <= 1'b0;
      end else begin
         case (state_q)
            ACK_IDLE: begin
               if (join_now) begin
                  state_q <= ACK_ARB;
                  bit_q   <= '0;
                  shift_q <= arb_num;
                  alive_q <= 1'b1;
                  src_q   <= top_is_spi;
               end
            end
            ACK_ARB: begin
               if (lose_now) alive_q <= 1'b0;
               shift_q <= {shift_q[ARB_W-2:0], 1'b1};
               if (bit_q == LAST_BIT) state_q <= ACK_RESP;
               else                   bit_q   <= bit_q + 1'b1;
            end
            default: begin
               state_q <= ACK_IDLE;
               alive_q <= 1'b0;
            end
         endcase
      end
   end

   assign release_o = ((state_q == ACK_ARB) && alive_q) ? cur_bit : 1'b1;
   assign vec_valid = (state_q == ACK_RESP) && alive_q;
   assign vec_num   = vec_valid ? {vec_base, src_q} : '0;
endmodule

// File: rtl/dual_irq_front.sv
module dual_irq_front #(
   parameter int LVL_W        = 3,
   parameter int ARB_W        = 4,
   parameter int VEC_W        = 8,
   parameter bit SPI_WINS_TIE = 1'b1,
   localparam int NUM_LINES   = (1 << LVL_W) - 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [1:0]           cfg_addr,
   input  logic [VEC_W-1:0]     cfg_data,
   input  logic                 spi_flag,
   input  logic                 ser_flag,
   output logic [NUM_LINES-1:0] irq_line,
   input  logic                 iack_start,
   input  logic [LVL_W-1:0]     iack_level,
   input  logic                 arb_bus_in,
   output logic                 arb_release,
   output logic                 vec_valid,
   output logic [VEC_W-1:0]     vec_num
);
   generate
      if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
         $error("LVL_W must lie in 1..4");
      end
      if (ARB_W < 2) begin : g_bad_arb
         $error("ARB_W must be at least 2");
      end
      if (VEC_W < 2 || VEC_W < ARB_W || VEC_W < LVL_W) begin : g_bad_vec
         $error("VEC_W must cover the level and arbitration fields");
      end
   endgenerate

   logic [LVL_W-1:0] lvl_spi;
   logic [LVL_W-1:0] lvl_ser;
   logic [ARB_W-1:0] arb_num;
   logic [VEC_W-2:0] vec_base;
   logic [LVL_W-1:0] top_level;
   logic             top_is_spi;

   dirq_cfg #(.LVL_W(LVL_W), .ARB_W(ARB_W), .VEC_W(VEC_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_sel   (cfg_addr),
      .wr_data  (cfg_data),
      .lvl_spi  (lvl_spi),
      .lvl_ser  (lvl_ser),
      .arb_num  (arb_num),
      .vec_base (vec_base)
   );

   dirq_level #(.LVL_W(LVL_W), .SPI_WINS_TIE(SPI_WINS_TIE)) u_level (
      .flag_spi   (spi_flag),
      .flag_ser   (ser_flag),
      .lvl_spi    (lvl_spi),
      .lvl_ser    (lvl_ser),
      .lines      (irq_line),
      .top_level  (top_level),
      .top_is_spi (top_is_spi)
   );

   dirq_contend #(.LVL_W(LVL_W), .ARB_W(ARB_W), .VEC_W(VEC_W)) u_contend (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (iack_start),
      .ack_level  (iack_level),
      .top_level  (top_level),
      .top_is_spi (top_is_spi),
      .arb_num    (arb_num),
      .vec_base   (vec_base),
      .bus_in     (arb_bus_in),
      .release_o  (arb_release),
      .vec_valid  (vec_valid),
      .vec_num    (vec_num)
   );
endmodule

// File: rtl/dual_irq_front_chk.sv
module dual_irq_front_chk #(
   parameter int NUM_LINES = 7,
   parameter int ARB_W     = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 spi_flag,
   input logic                 ser_flag,
   input logic [NUM_LINES-1:0] irq_line,
   input logic                 arb_release,
   input logic                 vec_valid,
   input logic [ARB_W-1:0]     arb_num
);
   assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_line));

   assert_no_flag_no_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_flag && !ser_flag) |-> (irq_line == '0));

   assert_vec_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   assert_vec_needs_number_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (arb_num != '0));

   assert_released_at_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> arb_release);
endmodule

bind dual_irq_front dual_irq_front_chk #(.NUM_LINES(NUM_LINES), .ARB_W(ARB_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_flag    (spi_flag),
   .ser_flag    (ser_flag),
   .irq_line    (irq_line),
   .arb_release (arb_release),
   .vec_valid   (vec_valid),
   .arb_num     (arb_num)
);

// File: tb/dual_irq_front_bench.sv
`timescale 1ns/1ps
module dual_irq_front_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_data = '0;
   logic       spi_flag = 1'b0;
   logic       ser_flag = 1'b0;
   logic [6:0] irq_line;
   logic       iack_start = 1'b0;
   logic [2:0] iack_level = '0;
   logic       oth_bit = 1'b1;
   logic       arb_bus_in;
   logic       arb_release;
   logic       vec_valid;
   logic [7:0] vec_num;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   assign arb_bus_in = arb_release & oth_bit;

   dual_irq_front u_dual_irq_front (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_addr (cfg_addr),
      .cfg_data (cfg_data), .spi_flag (spi_flag), .ser_flag (ser_flag),
      .irq_line (irq_line), .iack_start (iack_start), .iack_level (iack_level),
      .arb_bus_in (arb_bus_in), .arb_release (arb_release),
      .vec_valid (vec_valid), .vec_num (vec_num)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   function automatic int exp_lines(input int ls, input int lu, input bit fs, input bit fu);
      int es = fs ? ls : 0;
      int eu = fu ? lu : 0;
      int m = (es > eu) ? es : eu;
      return (m == 0) ? 0 : (1 << (m - 1));
   endfunction

   // one acknowledge cycle against a modelled rival holding number oth (0 = absent)
   task automatic ack(input int mask, input int oth, input int id,
                      input bit contend, input int exp_vec);
      bit win;
      @(negedge clk);
      iack_start = 1'b1; iack_level = 3'(mask);
      for (int k = 0; k < 4; k++) begin
         bit d_alive, o_alive, e_rel;
         @(negedge clk);
         iack_start = 1'b0;
         d_alive = contend && (oth == 0 || (id >> (4 - k)) <= (oth >> (4 - k)));
         o_alive = (oth != 0) && (!contend || (oth >> (4 - k)) <= (id >> (4 - k)));
         e_rel = d_alive ? id[3 - k] : 1'b1;
         oth_bit = o_alive ? oth[3 - k] : 1'b1;
         chk(arb_release == e_rel, "R6 contention bit", arb_release, e_rel);
         chk(vec_valid == 1'b0, "R7 no vector during contention", vec_valid, 0);
      end
      @(negedge clk);
      oth_bit = 1'b1;
      win = contend && (oth == 0 || id < oth);
      chk(vec_valid == win, "R4/R7 vector presence", vec_valid, win);
      if (win) chk(vec_num == exp_vec, "R8 vector number", vec_num, exp_vec);
      @(negedge clk);
      chk(vec_valid == 1'b0, "R7 single-cycle vector", vec_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      spi_flag = 1'b1; ser_flag = 1'b1;
      #1;
      chk(irq_line == 0, "R1 no line after reset", irq_line, 0);
      chk(arb_release == 1'b1, "R1 released after reset", arb_release, 1);
      chk(vec_valid == 1'b0, "R1 no vector after reset", vec_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_line == 0, "R1 zero levels give no line", irq_line, 0);
      ack(1, 0, 0, 1'b0, 0);

      // R2 R3: sweep both levels and flags
      for (int ls = 0; ls < 8; ls++) begin
         for (int lu = 0; lu < 8; lu++) begin
            wr(2'd0, 8'(ls));
            wr(2'd1, 8'(lu));
            for (int f = 0; f < 4; f++) begin
               int e;
               spi_flag = f[0]; ser_flag = f[1];
               #1;
               e = exp_lines(ls, lu, f[0], f[1]);
               chk(irq_line == 7'(e), "R2/R3 request line", irq_line, e);
            end
         end
      end

      // R10 R8: equal levels, SPI served on tie
      wr(2'd2, 8'd5);
      wr(2'd3, 8'h5A);
      wr(2'd0, 8'd4);
      wr(2'd1, 8'd4);
      spi_flag = 1'b1; ser_flag = 1'b1;
      for (int m = 0; m < 8; m++) begin
         ack(m, 0, 5, m == 4, 8'h5B);
         ack(m, 2, 5, m == 4, 8'h5B);
         ack(m, 9, 5, m == 4, 8'h5B);
         ack(m, 12, 5, m == 4, 8'h5B);
      end

      // R4 R9: serial source higher, mismatching mask, request held
      wr(2'd1, 8'd6);
      ack(4, 0, 5, 1'b0, 0);
      ack(6, 0, 5, 1'b1, 8'h5A);
      #1;
      chk(irq_line == 7'h20, "R9 line held after acknowledge", irq_line, 32'h20);

      // R8: only serial pending
      spi_flag = 1'b0;
      wr(2'd1, 8'd3);
      ack(3, 7, 5, 1'b1, 8'h5A);
      spi_flag = 1'b1; ser_flag = 1'b0;
      ack(4, 6, 5, 1'b1, 8'h5B);

      // R10: base low data bit ignored; R6 rival with more leading zeros
      wr(2'd3, 8'hF1);
      wr(2'd2, 8'd3);
      ack(4, 1, 3, 1'b1, 8'hF1);
      ack(4, 4, 3, 1'b1, 8'hF1);
      spi_flag = 1'b0; ser_flag = 1'b1;
      ack(3, 0, 3, 1'b1, 8'hF0);

      // R5: zero arbitration number never answers
      wr(2'd2, 8'd0);
      ack(3, 0, 0, 1'b0, 0);
      ack(3, 8, 0, 1'b0, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule